// File: doc/BRIEF.md
# Bit-Clock and Frame-Sync Generator

This block produces the bit clock and the frame-sync strobe for a synchronous serial audio port. A reference is divided down to a bit clock. Bit-clock periods are then counted to mark out frames. Three programmable fields set the timing, and each holds its value minus one: a divide count, a frame length in bit clocks, and a strobe width in bit clocks. Both outputs have their own polarity inversion. Output-enable signals tell the pad ring which pins this block drives.

The reference can be the system clock, or rising edges seen on the bit-clock pad when that pad is used as an input. In that external case the divider still applies, and the bit-clock output driver is turned off. In bit-clock slave mode, each rising edge on the pad is one bit period and the divide field is ignored. The frame strobe can still be generated and driven, which gives a mixed master/slave arrangement. A combinational check flags settings that cannot work: a frame shorter than word length times channel count, a divide-by-one ratio in a master mode, or the reserved mode code.

Top module: `frame_clock_gen`

## Requirements
- R1: In mode 0 (internal reference), the bit clock repeats every cfg_div+1 system clocks. Within each period it is low for floor((cfg_div+1)/2) clocks and then high for the rest.
- R2: A frame lasts cfg_period+1 bit periods. The frame strobe is active during bit periods 0 through cfg_width of each frame.
- R3: If cfg_width is greater than or equal to cfg_period, the active width becomes cfg_period bit periods, which leaves one inactive bit period. It becomes one bit period when cfg_period is 0, and the strobe then stays active.
- R4: When enable is low, the raw bit clock and the raw strobe are both low. The first clock edge that samples enable high restarts both counters at zero, so the strobe is active in the very next cycle and the bit clock starts in its low phase.
- R5: Changes to cfg_div, cfg_period or cfg_width made while running take effect only at the next frame boundary.
- R6: bclk_out is the raw bit clock XOR cfg_bclk_inv, and fs_out is the raw strobe XOR cfg_fs_inv.
- R7: bclk_oe is high only in mode 0. fs_oe equals cfg_fs_drive.
- R8: In mode 1 (external reference), each synchronized rising edge of bclk_pad_in is one reference tick. A frame therefore spans (cfg_div+1)*(cfg_period+1) pad rising edges.
- R9: In mode 2 (bit-clock slave), each synchronized rising edge of bclk_pad_in is one bit period and cfg_div is ignored. A frame spans cfg_period+1 pad rising edges.
- R10: cfg_err is high when cfg_period+1 < cfg_word_len*cfg_chans, when cfg_div is 0 in mode 0 or 1, or when the mode is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the internal reference |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the generator; the rising edge restarts it |
| cfg_div | input | 8 | Reference divide count minus one |
| cfg_period | input | 12 | Frame length in bit clocks minus one |
| cfg_width | input | 8 | Strobe width in bit clocks minus one |
| cfg_bclk_mode | input | 2 | 0 internal master, 1 external-reference master, 2 slave, 3 reserved |
| cfg_fs_drive | input | 1 | Drive the frame-sync pin |
| cfg_bclk_inv | input | 1 | Invert the bit clock |
| cfg_fs_inv | input | 1 | Invert the frame strobe |
| cfg_word_len | input | 6 | Bits per word, used by the check |
| cfg_chans | input | 5 | Words per frame, used by the check |
| bclk_pad_in | input | 1 | Bit-clock pad input, asynchronous |
| bclk_out | output | 1 | Bit clock to the pad |
| bclk_oe | output | 1 | Bit-clock pad output enable |
| fs_out | output | 1 | Frame strobe to the pad |
| fs_oe | output | 1 | Frame-sync pad output enable |
| cfg_err | output | 1 | Programmed values are unusable |

## Verification
The bench sweeps every combination of divide values 1 to 3, frame lengths 1 to 6, widths 1 to 7 and both polarities. A cycle-accurate arithmetic model checks each output on every cycle. This catches an off-by-one in either counter, which would stretch or shorten frames, and a missing width clamp, which would hold the strobe active for a whole frame. A mid-frame reprogram checks that the old frame finishes at its original length; a design that loaded the new values at once would emit a truncated frame. The external-reference and slave modes are checked by counting pad edges between strobe rises. That catches a divider wrongly applied or wrongly skipped. The error flag is checked on both sides of its bandwidth threshold.

// File: rtl/fcg_pkg.sv
// Shared types of the bit-clock / frame-sync generator.
package fcg_pkg;
    // Source of bit-clock timing.
    typedef enum logic [1:0] {
        MODE_INT   = 2'd0,
        MODE_EXT   = 2'd1,
        MODE_SLAVE = 2'd2,
        MODE_BAD   = 2'd3
    } bclk_mode_e;
endpackage

// File: rtl/fcg_edge_detect.sv
// Two-flop synchronizer plus rising-edge detector for an asynchronous pad.
// Assumes the pad stays high and low for at least two clk cycles each.
module fcg_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pad,
    output logic rise
);
    logic [2:0] sh;

    // Shift the pad through the synchronizer and the history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[1:0], pad};
    end

    assign rise = sh[1] & ~sh[2];
endmodule

// File: rtl/fcg_bit_divider.sv
// Divides reference ticks by div_lim+1 and gives the bit-clock phase.
// Assumes that clear is held whenever the generator is not running.
module fcg_bit_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [DIV_W-1:0] div_lim,
    output logic             bit_end,
    output logic             phase_hi
);
    logic [DIV_W-1:0] dcnt;
    logic [DIV_W:0]   half;

    // Count reference ticks within one bit period.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)  dcnt <= '0;
        else if (step)        dcnt <= (dcnt == div_lim) ? '0 : dcnt + 1'b1;
    end

    // The low phase lasts floor((div_lim+1)/2) ticks.
    always_comb begin
        half = ({1'b0, div_lim} + 1'b1) >> 1;
    end

    assign bit_end  = step && (dcnt == div_lim);
    assign phase_hi = ({1'b0, dcnt} >= half);

    a_r1_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        dcnt <= div_lim);
endmodule

// File: rtl/fcg_frame_timer.sv
// Counts bit periods into frames and holds the working copy of the timing
// fields, which it loads at start and at each frame boundary.
// Assumes WID_W < PER_W.
module fcg_frame_timer #(
    parameter int DIV_W = 8,
    parameter int PER_W = 12,
    parameter int WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             enable,
    input  logic             bit_end,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [PER_W-1:0] cfg_period,
    input  logic [WID_W-1:0] cfg_width,
    output logic [DIV_W-1:0] div_s,
    output logic             fs_act
);
    logic [PER_W-1:0] fcnt;
    logic [PER_W-1:0] per_s;
    logic [WID_W-1:0] wid_s;
    logic [WID_W-1:0] wid_clamped;
    logic             wrap;

    // Limit the width to at most period-1, or to 0 for a one-bit frame.
    always_comb begin
        if (cfg_period == '0)
            wid_clamped = '0;
        else if ({{(PER_W-WID_W){1'b0}}, cfg_width} >= cfg_period)
            wid_clamped = WID_W'(cfg_period - 1'b1);
        else
            wid_clamped = cfg_width;
    end

    assign wrap = bit_end && (fcnt == per_s);

    // Frame position counter with shadow loads at start and at the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt  <= '0;
            per_s <= '0;
            wid_s <= '0;
            div_s <= '0;
        end else if (!running) begin
            fcnt <= '0;
            if (enable) begin
                per_s <= cfg_period;
                wid_s <= wid_clamped;
                div_s <= cfg_div;
            end
        end else if (bit_end) begin
            if (wrap) begin
                fcnt  <= '0;
                per_s <= cfg_period;
                wid_s <= wid_clamped;
                div_s <= cfg_div;
            end else begin
                fcnt <= fcnt + 1'b1;
            end
        end
    end

    assign fs_act = running && (fcnt <= {{(PER_W-WID_W){1'b0}}, wid_s});

    a_r2_frame_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        fcnt <= per_s);
    a_r3_width_below_period: assert property (@(posedge clk) disable iff (!rst_n)
        (per_s == '0) || ({{(PER_W-WID_W){1'b0}}, wid_s} < per_s));
    a_r5_hold_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wrap) |=> ($stable(per_s) && $stable(wid_s) && $stable(div_s)));
endmodule

// File: rtl/frame_clock_gen.sv
// Top: bit-clock and frame-sync generator for a serial audio port.
// Chooses the reference, drives the divider and the frame timer, applies the
// polarities, sets the pad enables and checks the programmed values.
// Assumes the mode and polarity inputs stay static while enabled.
module frame_clock_gen
    import fcg_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int PER_W = 12,
    parameter int WID_W = 8,
    parameter int WL_W  = 6,
    parameter int CH_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [PER_W-1:0] cfg_period,
    input  logic [WID_W-1:0] cfg_width,
    input  logic [1:0]       cfg_bclk_mode,
    input  logic             cfg_fs_drive,
    input  logic             cfg_bclk_inv,
    input  logic             cfg_fs_inv,
    input  logic [WL_W-1:0]  cfg_word_len,
    input  logic [CH_W-1:0]  cfg_chans,
    input  logic             bclk_pad_in,
    output logic             bclk_out,
    output logic             bclk_oe,
    output logic             fs_out,
    output logic             fs_oe,
    output logic             cfg_err
);
    localparam int NEED_W = WL_W + CH_W;
    localparam int CMP_W  = (NEED_W > PER_W + 1) ? NEED_W : PER_W + 1;

    bclk_mode_e       mode;
    logic             running;
    logic             pad_rise;
    logic             div_step;
    logic             div_end;
    logic             bit_end;
    logic             phase_hi;
    logic             bclk_raw;
    logic             fs_raw;
    logic [DIV_W-1:0] div_s;
    logic [NEED_W-1:0] need_bits;
    logic [PER_W:0]   frame_bits;

    assign mode = bclk_mode_e'(cfg_bclk_mode);

    // Run flag: set by the first edge that sees enable, cleared without it.
    always_ff @(posedge clk) begin
        if (!rst_n) running <= 1'b0;
        else        running <= enable;
    end

    fcg_edge_detect u_pad (
        .clk   (clk),
        .rst_n (rst_n),
        .pad   (bclk_pad_in),
        .rise  (pad_rise)
    );

    // Reference tick: every clock internally, else one per pad rising edge.
    always_comb begin
        div_step = running && ((mode == MODE_INT) ? 1'b1 : pad_rise);
    end

    fcg_bit_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!running),
        .step     (div_step),
        .div_lim  (div_s),
        .bit_end  (div_end),
        .phase_hi (phase_hi)
    );

    // Bit boundary: from the divider in master modes, from the pad in slave.
    always_comb begin
        if (mode == MODE_INT || mode == MODE_EXT) bit_end = div_end;
        else                                      bit_end = running && pad_rise;
    end

    fcg_frame_timer #(.DIV_W(DIV_W), .PER_W(PER_W), .WID_W(WID_W)) u_frm (
        .clk        (clk),
        .rst_n      (rst_n),
        .running    (running),
        .enable     (enable),
        .bit_end    (bit_end),
        .cfg_div    (cfg_div),
        .cfg_period (cfg_period),
        .cfg_width  (cfg_width),
        .div_s      (div_s),
        .fs_act     (fs_raw)
    );

    // Raw bit clock exists only when this block times the bits.
    always_comb begin
        bclk_raw = running && phase_hi && (mode == MODE_INT || mode == MODE_EXT);
    end

    assign bclk_out = bclk_raw ^ cfg_bclk_inv;
    assign fs_out   = fs_raw ^ cfg_fs_inv;
    assign bclk_oe  = (mode == MODE_INT);
    assign fs_oe    = cfg_fs_drive;

    // Programmed-value check: bandwidth, divide ratio and mode code.
    always_comb begin
        need_bits  = NEED_W'(cfg_word_len) * NEED_W'(cfg_chans);
        frame_bits = {1'b0, cfg_period} + 1'b1;
        cfg_err    = (CMP_W'(frame_bits) < CMP_W'(need_bits))
                   || ((cfg_div == '0) && (mode == MODE_INT || mode == MODE_EXT))
                   || (mode == MODE_BAD);
    end

    a_r4_first_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |=> (fs_raw && !bclk_raw));
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!fs_raw && !bclk_raw));
    a_r7_pad_drive: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_oe |-> (cfg_bclk_mode == 2'd0));
    a_r9_slave_no_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SLAVE) |-> !bclk_raw);
endmodule

// File: tb/frame_clock_gen_test.sv
module frame_clock_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [7:0]  cfg_div = 8'd1;
    logic [11:0] cfg_period = 12'd3;
    logic [7:0]  cfg_width = 8'd0;
    logic [1:0]  cfg_bclk_mode = 2'd0;
    logic        cfg_fs_drive = 1'b1;
    logic        cfg_bclk_inv = 1'b0;
    logic        cfg_fs_inv = 1'b0;
    logic [5:0]  cfg_word_len = 6'd1;
    logic [4:0]  cfg_chans = 5'd1;
    logic        bclk_pad_in = 1'b0;
    logic        bclk_out, bclk_oe, fs_out, fs_oe, cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    string cur_tag = "R2";

    // Bench model state.
    bit m_run = 0;
    int m_dc = 0, m_fc = 0, m_div = 0, m_per = 0, m_wid = 0;

    always #5 clk = ~clk;

    frame_clock_gen uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_div(cfg_div),
        .cfg_period(cfg_period), .cfg_width(cfg_width),
        .cfg_bclk_mode(cfg_bclk_mode), .cfg_fs_drive(cfg_fs_drive),
        .cfg_bclk_inv(cfg_bclk_inv), .cfg_fs_inv(cfg_fs_inv),
        .cfg_word_len(cfg_word_len), .cfg_chans(cfg_chans),
        .bclk_pad_in(bclk_pad_in), .bclk_out(bclk_out), .bclk_oe(bclk_oe),
        .fs_out(fs_out), .fs_oe(fs_oe), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic model_load();
        m_div = int'(cfg_div);
        m_per = int'(cfg_period);
        if (m_per == 0) m_wid = 0;
        else if (int'(cfg_width) >= m_per) m_wid = m_per - 1;
        else m_wid = int'(cfg_width);
    endtask

    // One clock in internal mode: advance the model, then compare at the negedge.
    task automatic cyc(input bit check);
        @(posedge clk);
        if (!enable) m_run = 0;
        else if (!m_run) begin
            m_run = 1; m_dc = 0; m_fc = 0; model_load();
        end else if (m_dc == m_div) begin
            m_dc = 0;
            if (m_fc == m_per) begin m_fc = 0; model_load(); end
            else m_fc++;
        end else m_dc++;
        @(negedge clk);
        if (check) begin
            bit eb, ef;
            eb = (m_run && (m_dc >= (m_div + 1) / 2)) ^ cfg_bclk_inv;
            ef = (m_run && (m_fc <= m_wid)) ^ cfg_fs_inv;
            chk(bclk_out == eb, "R1/R6 bclk", int'(bclk_out), int'(eb));
            chk(fs_out == ef, cur_tag, int'(fs_out), int'(ef));
        end
    endtask

    // Count pad rising edges between strobe rises in modes 1 and 2.
    task automatic edge_frames(input string tag, input int exp);
        bit f_prev = 0;
        int edges = 0, nrise = 0;
        for (int i = 0; i < 600 && nrise < 4; i++) begin
            bit np;
            @(negedge clk);
            if (fs_out && !f_prev) begin
                if (nrise >= 1) chk(edges == exp, tag, edges, exp);
                edges = 0;
                nrise++;
            end
            f_prev = fs_out;
            np = ((i / 3) % 2) == 1;
            if (np && !bclk_pad_in) edges++;
            bclk_pad_in = np;
        end
        chk(nrise == 4, tag, nrise, 4);
    endtask

    initial begin
        #2_000_000;
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: idle after reset, R7 pad enables in mode 0.
        chk(bclk_out == 1'b0, "R4 reset bclk", int'(bclk_out), 0);
        chk(fs_out == 1'b0, "R4 reset fs", int'(fs_out), 0);
        chk(bclk_oe == 1'b1, "R7 bclk_oe", int'(bclk_oe), 1);
        chk(fs_oe == 1'b1, "R7 fs_oe", int'(fs_oe), 1);

        // R1 R2 R3 R6: sweep divide, period, width and polarities.
        for (int d = 1; d <= 3; d++)
            for (int p = 0; p <= 5; p++)
                for (int w = 0; w <= 6; w++)
                    for (int pol = 0; pol < 4; pol++) begin
                        enable = 1'b0;
                        cfg_div = 8'(d); cfg_period = 12'(p); cfg_width = 8'(w);
                        cfg_bclk_inv = pol[0]; cfg_fs_inv = pol[1];
                        cur_tag = (w >= p) ? "R3 fs" : "R2 fs";
                        cyc(1);
                        enable = 1'b1;
                        for (int k = 0; k < (d + 1) * (p + 1) * 2 + 3; k++) cyc(1);
                    end

        // R4: disable mid-frame, outputs idle, restart at frame position 0.
        cfg_bclk_inv = 0; cfg_fs_inv = 0;
        cfg_div = 8'd2; cfg_period = 12'd4; cfg_width = 8'd1;
        cur_tag = "R4 fs";
        for (int k = 0; k < 8; k++) cyc(1);
        enable = 1'b0;
        cyc(0);
        chk(fs_out == 1'b0, "R4 idle fs", int'(fs_out), 0);
        chk(bclk_out == 1'b0, "R4 idle bclk", int'(bclk_out), 0);
        enable = 1'b1;
        cyc(0);
        chk(fs_out == 1'b1, "R4 restart fs", int'(fs_out), 1);
        chk(bclk_out == 1'b0, "R4 restart bclk", int'(bclk_out), 0);

        // R5: reprogram in mid-frame; old frame runs to its end.
        cur_tag = "R5 fs";
        enable = 1'b0; cyc(1);
        cfg_div = 8'd1; cfg_period = 12'd5; cfg_width = 8'd2;
        enable = 1'b1;
        for (int k = 0; k < 5; k++) cyc(1);
        cfg_div = 8'd2; cfg_period = 12'd1; cfg_width = 8'd0;
        for (int k = 0; k < 30; k++) cyc(1);
        enable = 1'b0; cyc(1);

        // R7: pad enables per mode.
        for (int m = 0; m < 3; m++)
            for (int f = 0; f < 2; f++) begin
                cfg_bclk_mode = 2'(m); cfg_fs_drive = f[0];
                @(negedge clk);
                chk(bclk_oe == (m == 0), "R7 bclk_oe", int'(bclk_oe), int'(m == 0));
                chk(fs_oe == f[0], "R7 fs_oe", int'(fs_oe), f);
            end

        // R8: external reference divided; frame = (div+1)*(period+1) pad edges.
        cfg_bclk_mode = 2'd1; cfg_fs_drive = 1'b1;
        cfg_div = 8'd1; cfg_period = 12'd2; cfg_width = 8'd0;
        @(negedge clk); enable = 1'b1;
        edge_frames("R8 pad edges per frame", 6);
        enable = 1'b0; @(negedge clk);

        // R9: slave bit clock, divide ignored; frame = period+1 pad edges.
        cfg_bclk_mode = 2'd2;
        cfg_div = 8'd3;
        @(negedge clk); enable = 1'b1;
        edge_frames("R9 pad edges per frame", 3);
        enable = 1'b0; @(negedge clk);

        // R10: configuration check.
        cfg_bclk_mode = 2'd0; cfg_div = 8'd1;
        cfg_word_len = 6'd16; cfg_chans = 5'd2; cfg_period = 12'd31;
        @(negedge clk);
        chk(cfg_err == 1'b0, "R10 exact fit", int'(cfg_err), 0);
        cfg_period = 12'd30;
        @(negedge clk);
        chk(cfg_err == 1'b1, "R10 too short", int'(cfg_err), 1);
        cfg_period = 12'd63; cfg_div = 8'd0;
        @(negedge clk);
        chk(cfg_err == 1'b1, "R10 div zero master", int'(cfg_err), 1);
        cfg_bclk_mode = 2'd2;
        @(negedge clk);
        chk(cfg_err == 1'b0, "R10 div zero slave", int'(cfg_err), 0);
        cfg_bclk_mode = 2'd3; cfg_div = 8'd4;
        @(negedge clk);
        chk(cfg_err == 1'b1, "R10 reserved mode", int'(cfg_err), 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule